// File: doc/BRIEF.md
# Link Fault Ordered-Set Responder

This block watches the decoded receive column stream for fault sequence ordered sets and decides what the transmit side should put on the line. Upstream logic decodes each received column. It reports whether the column holds a local fault sequence, a remote fault sequence, some other ordered set, or no ordered set. The transmit side reports whether it is currently in an inter-packet gap. The block answers with two requests: insert a remote fault ordered set, or send idle only. It also reports which fault conditions are currently latched.

A per-type detector latches a fault only after a burst of identical fault ordered sets arrives close together with nothing else in between. It releases the fault after a long enough run of columns without that ordered set. A two-bit mode input picks how the latched faults drive transmit. Off makes no change. Unidirectional answers a local fault with remote fault sets placed only in the gaps and disregards a partner's remote fault. Bidirectional answers a local fault with continuous remote fault sets and a remote fault with idle only. Encoding the requested ordered sets into the transmit stream is left to the transmit path.

Top module: `link_fault_responder`

## Requirements
- R1: `cfgMode` encodes 0 = off, 1 = unidirectional, 2 = bidirectional, 3 = reserved. In modes 0 and 3, `sendRf` and `sendIdle` stay low whatever the fault flags and `txGap` are.
- R2: `osKind` encodes 0 = no ordered set, 1 = local fault sequence, 2 = remote fault sequence, 3 = any other ordered set. A column is counted only in a cycle with `colValid` high; cycles with `colValid` low have no effect on the fault flags.
- R3: A fault flag (`localFault` for kind 1, `remoteFault` for kind 2) rises at the clock edge that takes in the 4th column of that kind. The first and 4th of those columns must lie within a window of 128 counted columns, with no other ordered set between them.
- R4: Any ordered set of a different kind (including the other fault kind or kind 3) arriving between fault columns restarts that kind's count; the next fault column of the kind counts as the first.
- R5: A fault column arriving at or after the 129th counted column from the first of a partial sequence does not complete it; it starts a new sequence as its first column.
- R6: A latched fault flag falls at the edge that takes in the 128th consecutive counted column without that fault kind, and stays high up to then.
- R7: In unidirectional mode, `sendRf` equals `localFault` AND `txGap`, and `sendIdle` stays low.
- R8: In unidirectional mode, a latched remote fault changes neither `sendRf` nor `sendIdle`.
- R9: In bidirectional mode with a local fault latched, `sendRf` is high regardless of `txGap` and `sendIdle` is low.
- R10: In bidirectional mode with only a remote fault latched, `sendIdle` is high and `sendRf` is low.
- R11: In bidirectional mode with both faults latched, the local fault wins: `sendRf` high, `sendIdle` low.
- R12: While `rstN` is low and right after it, both flags and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgMode | input | 2 | Fault response mode (0 off, 1 unidirectional, 2 bidirectional, 3 reserved) |
| colValid | input | 1 | Received column is present this cycle |
| osKind | input | 2 | Kind of ordered set in the received column |
| txGap | input | 1 | Transmit side is in an inter-packet gap |
| sendRf | output | 1 | Request to insert a remote fault ordered set |
| sendIdle | output | 1 | Request to send idle only |
| localFault | output | 1 | Local fault condition latched |
| remoteFault | output | 1 | Remote fault condition latched |

## Verification
The response logic is swept over every mode and gap value in each of the four flag states: none, local only, remote only, and both. This separates gap-only insertion from continuous insertion, ignoring a remote fault from answering it with idle, and local priority from remote. The detector is driven with an unbroken burst, with bursts broken by a foreign ordered set of each kind, and with sequences whose fourth fault column falls on the last column inside the window and on the first column outside it. The release of each fault is checked one column before and exactly at the 128th quiet column, with the two faults offset so that they clear at different times.

// File: rtl/lfr_pkg.sv
package lfr_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_UNI  = 2'd1,
    MODE_BIDI = 2'd2,
    MODE_RSVD = 2'd3
  } lfMode_e;

  typedef enum logic [1:0] {
    OS_NONE   = 2'd0,
    OS_LOCAL  = 2'd1,
    OS_REMOTE = 2'd2,
    OS_OTHER  = 2'd3
  } osKind_e;

  // strobes handed from the detector datapath to the response control
  typedef struct packed {
    logic localHit;
    logic remoteHit;
  } faultStrobe_t;
endpackage

// File: rtl/lfr_detect.sv
module lfr_detect #(
  parameter int MATCH_COUNT = 4,
  parameter int WINDOW_COLS = 128,
  parameter int CLEAR_COLS  = 128,
  parameter logic [1:0] MY_KIND = 2'd1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       colValid,
  input  logic [1:0] osKind,
  output logic       faultOn
);
  localparam int CW = $clog2(MATCH_COUNT + 1);
  localparam int WW = $clog2(WINDOW_COLS + 1);
  localparam int QW = $clog2(CLEAR_COLS + 1);
  localparam logic [CW-1:0] HIT_LAST = CW'(MATCH_COUNT - 1);
  localparam logic [WW-1:0] WIN_END  = WW'(WINDOW_COLS);
  localparam logic [QW-1:0] Q_END    = QW'(CLEAR_COLS - 1);

  logic [CW-1:0] hits;
  logic [WW-1:0] winPos;
  logic [QW-1:0] quiet;
  logic          faultQ;
  logic          isMine;
  logic          isOther;

  assign isMine  = colValid && (osKind == MY_KIND);
  assign isOther = colValid && (osKind != lfr_pkg::OS_NONE) && (osKind != MY_KIND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hits   <= '0;
      winPos <= '0;
      quiet  <= '0;
      faultQ <= 1'b0;
    end else if (colValid) begin
      if (isMine) begin
        quiet <= '0;
        if (hits == '0 || winPos == WIN_END) begin
          hits   <= CW'(1);
          winPos <= WW'(1);
        end else if (hits == HIT_LAST) begin
          faultQ <= 1'b1;
          hits   <= '0;
          winPos <= '0;
        end else begin
          hits   <= hits + 1'b1;
          winPos <= winPos + 1'b1;
        end
      end else begin
        if (isOther) begin
          hits   <= '0;
          winPos <= '0;
        end else if (hits != '0) begin
          if (winPos == WIN_END) begin
            hits   <= '0;
            winPos <= '0;
          end else begin
            winPos <= winPos + 1'b1;
          end
        end
        if (faultQ) begin
          if (quiet == Q_END) begin
            faultQ <= 1'b0;
            quiet  <= '0;
          end else begin
            quiet <= quiet + 1'b1;
          end
        end
      end
    end
  end

  assign faultOn = faultQ;

  AST_SET_ON_MINE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultQ) |-> $past(isMine)); // R3
  AST_CLEAR_ON_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultQ) |-> $past(colValid && !isMine)); // R6
  AST_HOLD_ON_MINE: assert property (@(posedge clk) disable iff (!rstN)
    (faultQ && isMine) |=> faultQ); // R6
  AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |=> $stable(faultQ)); // R2
  AST_HITS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    hits <= HIT_LAST); // R4
endmodule

// File: rtl/lfr_ctrl.sv
module lfr_ctrl (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgMode,
  input  logic                  txGap,
  input  lfr_pkg::faultStrobe_t faults,
  output logic                  sendRf,
  output logic                  sendIdle
);
  import lfr_pkg::*;

  always_comb begin
    sendRf   = 1'b0;
    sendIdle = 1'b0;
    case (lfMode_e'(cfgMode))
      MODE_UNI: begin
        sendRf = faults.localHit && txGap;
      end
      MODE_BIDI: begin
        if (faults.localHit) begin
          sendRf = 1'b1;
        end else if (faults.remoteHit) begin
          sendIdle = 1'b1;
        end
      end
      default: begin
        sendRf   = 1'b0;
        sendIdle = 1'b0;
      end
    endcase
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd0 || cfgMode == 2'd3) |-> (!sendRf && !sendIdle)); // R1
  AST_UNI_GAP_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1 && sendRf) |-> txGap); // R7
  AST_UNI_NO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd1) |-> !sendIdle); // R8
  AST_LOCAL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == 2'd2 && faults.localHit) |-> (sendRf && !sendIdle)); // R11
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones({sendRf, sendIdle}) <= 1); // R10
endmodule

// File: rtl/link_fault_responder.sv
module link_fault_responder #(
  parameter int MATCH_COUNT = 4,
  parameter int WINDOW_COLS = 128,
  parameter int CLEAR_COLS  = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgMode,
  input  logic       colValid,
  input  logic [1:0] osKind,
  input  logic       txGap,
  output logic       sendRf,
  output logic       sendIdle,
  output logic       localFault,
  output logic       remoteFault
);
  localparam int NUM_KINDS = 2;

  logic [NUM_KINDS-1:0]  flagVec;
  lfr_pkg::faultStrobe_t strobes;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_det
    lfr_detect #(
      .MATCH_COUNT(MATCH_COUNT),
      .WINDOW_COLS(WINDOW_COLS),
      .CLEAR_COLS (CLEAR_COLS),
      .MY_KIND    (2'(k + 1))
    ) u_det (
      .clk     (clk),
      .rstN    (rstN),
      .colValid(colValid),
      .osKind  (osKind),
      .faultOn (flagVec[k])
    );
  end

  assign strobes.localHit  = flagVec[0];
  assign strobes.remoteHit = flagVec[1];

  lfr_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgMode (cfgMode),
    .txGap   (txGap),
    .faults  (strobes),
    .sendRf  (sendRf),
    .sendIdle(sendIdle)
  );

  assign localFault  = flagVec[0];
  assign remoteFault = flagVec[1];
endmodule

// File: tb/tb_link_fault_responder.sv
module tb_link_fault_responder;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cfgMode;
  logic       colValid;
  logic [1:0] osKind;
  logic       txGap;
  logic       sendRf, sendIdle, localFault, remoteFault;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_fault_responder dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .colValid(colValid),
    .osKind(osKind), .txGap(txGap), .sendRf(sendRf), .sendIdle(sendIdle),
    .localFault(localFault), .remoteFault(remoteFault)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // drive n counted columns of one kind, then one cycle with no column
  task automatic cols(input logic [1:0] k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      colValid = 1'b1;
      osKind   = k;
      @(posedge clk);
      #1;
    end
    @(negedge clk);
    colValid = 1'b0;
    osKind   = 2'd0;
    #1;
  endtask

  task automatic flags(input string req, input logic l, input logic r);
    check(req, "localFault", localFault, l);
    check(req, "remoteFault", remoteFault, r);
  endtask

  // sweep every mode and gap value with the flags in a known state
  task automatic sweep(input logic l, input logic r);
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 2; g++) begin
        logic eRf, eIdle;
        string req;
        @(negedge clk);
        cfgMode = 2'(m);
        txGap   = 1'(g);
        #1;
        eRf   = (m == 1) ? (l & 1'(g)) : (m == 2) ? l : 1'b0;
        eIdle = (m == 2) && !l && r;
        if (m == 0 || m == 3) req = "R1";
        else if (m == 1) req = r ? "R8" : "R7";
        else req = (l && r) ? "R11" : (l ? "R9" : "R10");
        check(req, "sendRf", sendRf, eRf);
        check(req, "sendIdle", sendIdle, eIdle);
      end
    end
    @(negedge clk);
    cfgMode = 2'd2;
    txGap   = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; cfgMode = 2'd2; colValid = 1'b0; osKind = 2'd0; txGap = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R12", "sendRf", sendRf, 1'b0);
    check("R12", "sendIdle", sendIdle, 1'b0);
    flags("R12", 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    flags("R12", 1'b0, 1'b0);
    sweep(1'b0, 1'b0);

    // R2: uncounted cycles carry no weight
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); colValid = 1'b0; osKind = 2'd1;
    end
    @(negedge clk); osKind = 2'd0;
    flags("R2", 1'b0, 1'b0);

    // R3: four local fault columns
    cols(2'd1, 3);
    flags("R3", 1'b0, 1'b0);
    cols(2'd1, 1);
    flags("R3", 1'b1, 1'b0);
    sweep(1'b1, 1'b0);
    cols(2'd2, 4);
    flags("R3", 1'b1, 1'b1);
    sweep(1'b1, 1'b1);

    // R6: local has 4 quiet columns, remote none
    cols(2'd0, 123);
    flags("R6", 1'b1, 1'b1);
    cols(2'd0, 1);
    flags("R6", 1'b0, 1'b1);
    sweep(1'b0, 1'b1);
    cols(2'd0, 3);
    flags("R6", 1'b0, 1'b1);
    cols(2'd0, 1);
    flags("R6", 1'b0, 1'b0);

    // R4: other ordered set interrupts
    cols(2'd1, 3); cols(2'd3, 1); cols(2'd1, 1);
    flags("R4", 1'b0, 1'b0);
    cols(2'd1, 3);
    flags("R4", 1'b1, 1'b0);
    cols(2'd0, 128);
    flags("R6", 1'b0, 1'b0);
    cols(2'd1, 3); cols(2'd2, 1); cols(2'd1, 1);
    flags("R4", 1'b0, 1'b0);
    cols(2'd1, 3);
    flags("R4", 1'b1, 1'b0);
    cols(2'd0, 128);
    flags("R6", 1'b0, 1'b0);

    // R5: fourth column on the last window column, then one past it
    cols(2'd1, 3); cols(2'd0, 124); cols(2'd1, 1);
    flags("R5", 1'b1, 1'b0);
    cols(2'd0, 128);
    flags("R6", 1'b0, 1'b0);
    cols(2'd1, 3); cols(2'd0, 125); cols(2'd1, 1);
    flags("R5", 1'b0, 1'b0);
    cols(2'd1, 3);
    flags("R5", 1'b1, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule